// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This unit sits in the fetch path of a 32-bit integer pipeline. It decodes one control-transfer word per strobe and computes the address to fetch next. Its inputs are the address of the word being decoded, the word itself and the four integer condition flags. It returns the next address, a flag telling whether control was transferred, and a flag telling whether the following delay-slot word should be squashed.

Two PC-relative formats are recognised:
- **Conditional branch.** A 4-bit condition field is evaluated against the flags, covering the signed, unsigned and raw-flag tests. A 22-bit word displacement gives the taken target.
- **Call.** A 30-bit word displacement gives the target, and the call is always taken.

Every other word falls through to the sequential address. The squash flag is only reported; sequencing of the delay slot is left to the surrounding pipeline.

A two-state controller tracks whether a result has been produced:
- **ST_EMPTY** is entered on reset. All outputs are zero.
- The transition **first_load** moves ST_EMPTY to ST_HOLD on the first valid strobe.
- **ST_HOLD** stays in place. It reloads the outputs on each later strobe and keeps them otherwise.

Results are registered, so they appear one clock after the strobe.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted (active low), and afterwards until the first valid strobe, out_npc, out_taken and out_annul are all zero.
- R2: A word is a conditional branch only when bits 31:30 are 00 and bits 24:22 are 010; bit 29 is the squash bit, bits 28:25 the condition and bits 21:0 the displacement. A word with bits 31:30 = 00 and any other value in bits 24:22 is treated as R9.
- R3: A taken branch yields out_npc = in_pc + (sign-extended bits 21:0) * 4, modulo 2^PC_W, and out_taken = 1.
- R4: A branch that is not taken yields out_npc = in_pc + 4, modulo 2^PC_W, and out_taken = 0.
- R5: The signed conditions, as flags {N,Z,V,C} = in_icc[3:0], are: 0001 eq = Z, 1001 ne = !Z, 1010 gt = !(Z|(N^V)), 0010 le = Z|(N^V), 1011 ge = !(N^V), 0011 lt = N^V.
- R6: The unsigned conditions are: 1100 gtu = !(C|Z), 0100 leu = C|Z, 1101 carry-clear = !C, 0101 carry-set = C.
- R7: The raw conditions are: 1110 = !N, 0110 = N, 1111 = !V, 0111 = V, 1000 always taken, 0000 never taken.
- R8: A word with bits 31:30 = 01 is a call. The call is taken with out_npc = in_pc + (sign-extended bits 29:0) * 4, modulo 2^PC_W, and out_annul = 0.
- R9: Any word that is neither a branch nor a call gives out_taken = 0, out_annul = 0 and out_npc = in_pc + 4.
- R10: For a branch, out_annul = 1 exactly when bit 29 is 1 and either the branch is not taken or the condition is 1000.
- R11: Outputs update on the clock edge that samples in_valid = 1 and keep their values on every edge where in_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: decode this cycle's word |
| in_pc | input | PC_W | Address of the word being decoded |
| in_instr | input | 32 | Instruction word |
| in_icc | input | 4 | Condition flags {N,Z,V,C} |
| out_npc | output | PC_W | Next fetch address |
| out_taken | output | 1 | Control transfer taken |
| out_annul | output | 1 | Delay-slot squash indication |

## Verification
The bench builds the unit with the default PC_W of 32. At this width the modular target arithmetic can be checked against a plain 32-bit integer model: wrap-around at the top of the address space, and negative displacements at their extreme values. Every condition code is swept against all sixteen flag combinations, with the squash bit both clear and set. Idle gaps between strobes exercise the hold behaviour.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam logic [1:0] OP_BRANCH   = 2'b00;
    localparam logic [1:0] OP_CALL     = 2'b01;
    localparam logic [2:0] OP2_BCOND   = 3'b010;
    localparam int         BR_DISP_W   = 22;
    localparam int         CALL_DISP_W = 30;
    localparam int         INSTR_W     = 32;

    typedef enum logic [3:0] {
        C_NEVER  = 4'h0, C_EQ  = 4'h1, C_LE  = 4'h2, C_LT  = 4'h3,
        C_LEU    = 4'h4, C_CS  = 4'h5, C_NEG = 4'h6, C_VS  = 4'h7,
        C_ALWAYS = 4'h8, C_NE  = 4'h9, C_GT  = 4'hA, C_GE  = 4'hB,
        C_GTU    = 4'hC, C_CC  = 4'hD, C_POS = 4'hE, C_VC  = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } icc_t;

    typedef enum logic [1:0] {
        K_OTHER  = 2'd0,
        K_BRANCH = 2'd1,
        K_CALL   = 2'd2
    } kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } st_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [INSTR_W-1:0]     instr,
    output kind_e                  kind,
    output logic                   squash_bit,
    output cond_e                  cond,
    output logic [BR_DISP_W-1:0]   disp_br,
    output logic [CALL_DISP_W-1:0] disp_call
);
    logic [1:0] op;
    logic [2:0] op2;

    always_comb begin
        op         = instr[31:30];
        op2        = instr[24:22];
        squash_bit = instr[29];
        cond       = cond_e'(instr[28:25]);
        disp_br    = instr[BR_DISP_W-1:0];
        disp_call  = instr[CALL_DISP_W-1:0];
        if (op == OP_CALL)
            kind = K_CALL;
        else if (op == OP_BRANCH && op2 == OP2_BCOND)
            kind = K_BRANCH;
        else
            kind = K_OTHER;
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  cond_e cond,
    input  icc_t  icc,
    output logic  take
);
    logic sgn_lt;
    logic uns_le;

    always_comb begin
        sgn_lt = icc.n ^ icc.v;
        uns_le = icc.c | icc.z;
        unique case (cond)
            C_NEVER:  take = 1'b0;
            C_EQ:     take = icc.z;
            C_LE:     take = icc.z | sgn_lt;
            C_LT:     take = sgn_lt;
            C_LEU:    take = uns_le;
            C_CS:     take = icc.c;
            C_NEG:    take = icc.n;
            C_VS:     take = icc.v;
            C_ALWAYS: take = 1'b1;
            C_NE:     take = ~icc.z;
            C_GT:     take = ~(icc.z | sgn_lt);
            C_GE:     take = ~sgn_lt;
            C_GTU:    take = ~uns_le;
            C_CC:     take = ~icc.c;
            C_POS:    take = ~icc.n;
            C_VC:     take = ~icc.v;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign ext = disp[PC_W-1:0];
        end
    endgenerate

    assign target = pc + (ext << 2);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    in_pc,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [3:0]         in_icc,
    output logic [PC_W-1:0]    out_npc,
    output logic               out_taken,
    output logic               out_annul
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    kind_e                  kind;
    logic                   squash_bit;
    cond_e                  cond;
    logic [BR_DISP_W-1:0]   disp_br;
    logic [CALL_DISP_W-1:0] disp_call;
    logic                   take;
    logic [PC_W-1:0]        br_tgt;
    logic [PC_W-1:0]        call_tgt;
    logic [PC_W-1:0]        seq_pc;

    logic [PC_W-1:0]        npc_d;
    logic                   taken_d;
    logic                   annul_d;

    st_e                    st_q;
    st_e                    st_d;

    npc_decode u_decode (
        .instr      (in_instr),
        .kind       (kind),
        .squash_bit (squash_bit),
        .cond       (cond),
        .disp_br    (disp_br),
        .disp_call  (disp_call)
    );

    npc_cond u_cond (
        .cond (cond),
        .icc  (icc_t'(in_icc)),
        .take (take)
    );

    npc_target #(.PC_W(PC_W), .DISP_W(BR_DISP_W)) u_br_tgt (
        .pc     (in_pc),
        .disp   (disp_br),
        .target (br_tgt)
    );

    npc_target #(.PC_W(PC_W), .DISP_W(CALL_DISP_W)) u_call_tgt (
        .pc     (in_pc),
        .disp   (disp_call),
        .target (call_tgt)
    );

    assign seq_pc = in_pc + STEP;

    always_comb begin
        unique case (kind)
            K_BRANCH: begin
                taken_d = take;
                npc_d   = take ? br_tgt : seq_pc;
                annul_d = squash_bit & (~take | (cond == C_ALWAYS));
            end
            K_CALL: begin
                taken_d = 1'b1;
                npc_d   = call_tgt;
                annul_d = 1'b0;
            end
            default: begin
                taken_d = 1'b0;
                npc_d   = seq_pc;
                annul_d = 1'b0;
            end
        endcase
    end

    // Controller: ST_EMPTY --first_load--> ST_HOLD, then ST_HOLD stays.
    always_comb begin
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_HOLD : ST_EMPTY;
            ST_HOLD:  st_d = ST_HOLD;
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_npc   <= '0;
            out_taken <= 1'b0;
            out_annul <= 1'b0;
        end else if (in_valid) begin
            out_npc   <= npc_d;
            out_taken <= taken_d;
            out_annul <= annul_d;
        end
    end

    p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EMPTY |-> (out_npc == '0 && !out_taken && !out_annul));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_npc) && $stable(out_taken) && $stable(out_annul)));

    p_call_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[31:30] == 2'b01 |=> (out_taken && !out_annul));

    p_other_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_instr[31:30] == 2'b10 || in_instr[31:30] == 2'b11)
        |=> (!out_taken && !out_annul && out_npc == $past(in_pc) + STEP));

    p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[31:30] == 2'b00 && in_instr[24:22] == 3'b010
        && in_instr[28:25] == 4'b1000 |=> out_taken);

    p_annul_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[31:30] == 2'b00 && in_instr[24:22] == 3'b010
        && !in_instr[29] |=> !out_annul);

    p_fallthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[31:30] == 2'b00 && in_instr[24:22] == 3'b010
        && in_instr[28:25] == 4'b0000 |=> (!out_taken && out_npc == $past(in_pc) + STEP));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_instr = '0;
    logic [3:0]  in_icc = '0;
    logic [31:0] out_npc;
    logic        out_taken;
    logic        out_annul;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_npc   = '0;
    logic        exp_taken = 1'b0;
    logic        exp_annul = 1'b0;
    string tg_t = "R1", tg_n = "R1", tg_a = "R1";

    always #5 clk = ~clk;

    npc_unit #(.PC_W(32)) u_npc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_instr(in_instr), .in_icc(in_icc), .out_npc(out_npc),
        .out_taken(out_taken), .out_annul(out_annul)
    );

    function automatic bit cond_hit(logic [3:0] c, logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1], cy = f[0];
        bit r;
        case (c[2:0])
            3'd0: r = 1'b0;
            3'd1: r = z;
            3'd2: r = z | (n ^ v);
            3'd3: r = n ^ v;
            3'd4: r = cy | z;
            3'd5: r = cy;
            3'd6: r = n;
            default: r = v;
        endcase
        return c[3] ? !r : r;
    endfunction

    function automatic string cond_tag(logic [3:0] c);
        case (c)
            4'h1, 4'h2, 4'h3, 4'h9, 4'hA, 4'hB: return "R5";
            4'h4, 4'h5, 4'hC, 4'hD:             return "R6";
            default:                           return "R7";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic on word displacements.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_npc = '0; exp_taken = 1'b0; exp_annul = 1'b0;
            tg_t = "R1"; tg_n = "R1"; tg_a = "R1";
        end else if (in_valid) begin
            longint d;
            if (in_instr[31:30] == 2'b01) begin
                d = longint'(in_instr[29:0]);
                if (d >= (64'sd1 <<< 29)) d = d - (64'sd1 <<< 30);
                exp_taken = 1'b1;
                exp_npc   = 32'(longint'(in_pc) + d * 4);
                exp_annul = 1'b0;
                tg_t = "R8"; tg_n = "R8"; tg_a = "R8";
            end else if (in_instr[31:30] == 2'b00 && in_instr[24:22] == 3'b010) begin
                bit t;
                t = cond_hit(in_instr[28:25], in_icc);
                d = longint'(in_instr[21:0]);
                if (d >= (64'sd1 <<< 21)) d = d - (64'sd1 <<< 22);
                exp_taken = t;
                exp_npc   = t ? 32'(longint'(in_pc) + d * 4) : 32'(longint'(in_pc) + 4);
                exp_annul = in_instr[29] && (!t || in_instr[28:25] == 4'h8);
                tg_t = cond_tag(in_instr[28:25]);
                tg_n = t ? "R3" : "R4";
                tg_a = "R10";
            end else begin
                exp_taken = 1'b0;
                exp_npc   = 32'(longint'(in_pc) + 4);
                exp_annul = 1'b0;
                tg_t = (in_instr[31:30] == 2'b00) ? "R2" : "R9";
                tg_n = tg_t; tg_a = tg_t;
            end
        end else begin
            tg_t = "R11"; tg_n = "R11"; tg_a = "R11";
        end
    end

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(out_taken == exp_taken, tg_t, "taken", out_taken, exp_taken);
            chk(out_npc == exp_npc, tg_n, "npc", out_npc, exp_npc);
            chk(out_annul == exp_annul, tg_a, "annul", out_annul, exp_annul);
        end
    end

    task automatic issue(logic [31:0] pc, logic [31:0] w, logic [3:0] f);
        @(negedge clk);
        in_valid = 1'b1; in_pc = pc; in_instr = w; in_icc = f;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pc = in_pc ^ 32'h5A5A_0000;
            in_instr = ~in_instr;
            in_icc = ~in_icc;
        end
    endtask

    function automatic logic [31:0] mk_br(bit a, logic [3:0] c, logic [21:0] d);
        return {2'b00, a, c, 3'b010, d};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);                               // R1: still zero before first strobe
        // R3 R4 R5 R6 R7 R10: every condition against every flag pattern
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                for (int a = 0; a < 2; a++)
                    issue(32'h0040_0000 + 32'(c * 256 + f * 8),
                          mk_br(a[0], c[3:0], 22'((c * 977 + f * 131) ^ (a ? 22'h200000 : 22'h0))),
                          f[3:0]);
        idle(3);                               // R11 hold
        // R3 extremes and wrap
        issue(32'h0000_0010, mk_br(1'b0, 4'h8, 22'h200000), 4'h0);
        issue(32'hFFFF_FFF0, mk_br(1'b0, 4'h8, 22'h1FFFFF), 4'h0);
        issue(32'hFFFF_FFFC, mk_br(1'b1, 4'h0, 22'h000010), 4'hF); // R4 wrap to 0
        // R8 calls
        issue(32'h1000_0000, {2'b01, 30'h0000_0004}, 4'h0);
        issue(32'h1000_0000, {2'b01, 30'h2000_0000}, 4'hF);
        issue(32'h0000_0008, {2'b01, 30'h3FFF_FFFF}, 4'h5);
        idle(1);
        // R9 and R2: other op / op2 values
        issue(32'h2000_0000, {2'b10, 30'h1234_5678}, 4'h4);
        issue(32'h2000_0004, {2'b11, 30'h3FFF_FFFF}, 4'hF);
        for (int o = 0; o < 8; o++)
            if (o != 2)
                issue(32'h3000_0000 + 32'(o * 4), {2'b00, 1'b1, 4'h8, o[2:0], 22'h00_0100}, 4'h4);
        idle(2);
        issue(32'h0050_0000, mk_br(1'b1, 4'h8, 22'h000040), 4'h0); // R10 always with squash
        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule